// File: doc/BRIEF.md
# DMA transfer length controller

This block starts and steps one DMA information transfer for a SCSI host adapter. Software loads a 24-bit transfer count one byte at a time. It then issues a start together with a signed residual size and a command-mode flag. The block copies the staged count into a working count and waits for the DMA-enable input. It then works out the transfer length and issues memory requests in chunks, each sized to what the device-side buffer currently offers.

After each acknowledged chunk the block lowers the bytes-left count and moves the residual toward zero by the chunk size. It finishes by setting terminal-count status and the bus-service flag, clearing the working count and raising the interrupt. When the DMA count runs out together with the device buffer but the device still holds data, the finish waits until the device next offers bytes. An abort input returns the block to idle without an interrupt.

Top module: `xfer_len_ctrl`

## Requirements
- R1: A count write with `cnt_sel` 0, 1 or 2 loads the low, middle or high byte of a staged 24-bit count, in any write order. A start copies the staged count to `count_q` on the start edge.
- R2: A working count of zero is taken as 65536 bytes when the length is computed.
- R3: In command mode the length is the smaller of the count and 16. The transfer is one memory read of that length, issued without waiting for device data, and its acknowledge completes the transfer.
- R4: Outside command mode the length is the smaller of the count and the magnitude of the signed residual. It appears on `left_q` one edge after DMA enable is seen.
- R5: `mem_to_dev` is 1 (memory read) for a negative residual or command mode, and 0 (memory write) for a non-negative residual.
- R6: While DMA enable is low after a start, `busy` stays high and no memory request is made. The transfer proceeds once enable is high.
- R7: Each request length in data mode is the smaller of the bytes left and the bytes the device buffer offers, and is never zero. With no device bytes available, no request is made.
- R8: An acknowledged chunk lowers `left_q` by its length and moves `residual_q` toward zero by the same amount.
- R9: Completion sets `stat_tc`, `intr_bs` and `irq`, zeroes `count_q` and drops `busy`. It happens right after a chunk that leaves device bytes unused, right after the residual reaches zero, and at once when the initial length is zero.
- R10: If a data-mode chunk empties both the bytes-left count and the device buffer while the residual is non-zero, `busy` stays high and `irq` low. Completion follows on the next device offer.
- R11: A start clears `stat_tc`, and so does any count byte write. An `irq_ack` clears `irq` and `intr_bs` but leaves `stat_tc` set.
- R12: `abort` while busy returns the block to idle on the next edge: `busy` and `mem_req` low, and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr | input | 1 | Count byte write strobe |
| cnt_sel | input | 2 | Byte select: 0 low, 1 middle, 2 high |
| cnt_wdata | input | 8 | Count byte value |
| start | input | 1 | Start pulse, taken only when idle |
| cmd_mode | input | 1 | Transfer carries command bytes |
| residual | input | 25 | Signed residual size; sign gives direction |
| dma_en | input | 1 | DMA enable from the DMA engine |
| abort | input | 1 | Abandon the current transfer |
| dev_offer | input | 1 | Device buffer offers new bytes |
| dev_offer_len | input | 25 | Number of bytes offered |
| mem_ack | input | 1 | Memory port finished the requested chunk |
| irq_ack | input | 1 | Interrupt acknowledge |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory chunk request |
| mem_to_dev | output | 1 | 1: read memory toward device; 0: write memory |
| mem_len | output | 25 | Requested chunk length |
| left_q | output | 25 | Bytes left in this DMA transfer |
| residual_q | output | 25 | Signed residual remaining |
| count_q | output | 24 | Working transfer count |
| stat_tc | output | 1 | Terminal-count status |
| intr_bs | output | 1 | Bus-service interrupt flag |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that `mem_ack` is only pulsed while `mem_req` is high, and that `start` arrives only when the block is idle. They also assume that `dev_offer` never lands in the same cycle as an acknowledged chunk, so the device-byte count is not overwritten mid-transfer. The bench meets these assumptions by design. It offers device bytes only when its own model says the buffer is empty, or while the block waits in the deferred state. It acknowledges only after it has seen a request, and it starts a new transfer only after it has checked and acknowledged the previous completion. Random counts cover the zero, small and large ranges. Random residual magnitudes stay below 160 so that each transfer ends within a few hundred chunks.

// File: rtl/xfer_len_pkg.sv
package xfer_len_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_RUN   = 3'd2,
        ST_XFER  = 3'd3,
        ST_DEFER = 3'd4
    } xfer_st_e;

endpackage

// File: rtl/xfer_count_regs.sv
module xfer_count_regs #(
    parameter int unsigned CNT_BYTES = 3,
    parameter int unsigned SEL_W     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [7:0]             wr_data,
    input  logic                   load,
    input  logic                   clear,
    output logic [8*CNT_BYTES-1:0] count_q,
    output logic                   wr_hit
);
    localparam int unsigned CNT_W = 8 * CNT_BYTES;

    typedef struct packed {
        logic [CNT_W-1:0] stage;
        logic [CNT_W-1:0] work;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_BYTES-1:0] byte_hit;

    // one decoder per count byte
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_hit
        assign byte_hit[b] = wr_en && (wr_sel == SEL_W'(b));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (byte_hit[i]) begin
                st_d.stage[8*i +: 8] = wr_data;
            end
        end
        if (load) begin
            st_d.work = st_q.stage;
        end
        if (clear) begin
            st_d.work = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.work;
    assign wr_hit  = |byte_hit;

    // R1: a start copies the staged bytes into the working count
    p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (count_q == $past(st_q.stage)));

endmodule

// File: rtl/xfer_len_clamp.sv
module xfer_len_clamp #(
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned W        = 25,
    parameter int unsigned CMD_BUF  = 16,
    parameter int unsigned ZERO_LEN = 65536
) (
    input  logic [CNT_W-1:0] count,
    input  logic [W-1:0]     residual,
    input  logic             cmd_mode,
    output logic [W-1:0]     len,
    output logic             to_dev
);
    logic [W-1:0] eff_cnt;
    logic [W-1:0] magnitude;
    logic [W-1:0] limit;

    always_comb begin
        eff_cnt   = (count == '0) ? W'(ZERO_LEN) : W'(count);
        magnitude = residual[W-1] ? (~residual + W'(1)) : residual;
        limit     = cmd_mode ? W'(CMD_BUF) : magnitude;
        len       = (eff_cnt < limit) ? eff_cnt : limit;
        to_dev    = cmd_mode | residual[W-1];
    end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_len_pkg::*;
#(
    parameter int unsigned W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmd_in,
    input  logic [W-1:0] res_in,
    input  logic         dma_en,
    input  logic         abort,
    input  logic         dev_offer,
    input  logic [W-1:0] dev_offer_len,
    input  logic         mem_ack,
    input  logic         irq_ack,
    input  logic         cnt_wr_hit,
    input  logic [W-1:0] calc_len,
    input  logic         calc_to_dev,
    output logic         load_cnt,
    output logic         clr_cnt,
    output logic [W-1:0] res_q,
    output logic         cmd_q,
    output logic         busy,
    output logic         mem_req,
    output logic         mem_to_dev,
    output logic [W-1:0] mem_len,
    output logic [W-1:0] left_q,
    output logic         stat_tc,
    output logic         intr_bs,
    output logic         irq
);
    typedef struct packed {
        xfer_st_e     state;
        logic [W-1:0] left;
        logic [W-1:0] avail;
        logic [W-1:0] res;
        logic [W-1:0] chunk;
        logic         to_dev;
        logic         cmd;
        logic         tc;
        logic         bs;
        logic         irq;
    } seq_t;

    seq_t q, d;
    logic [W-1:0] take, left_nx, avail_nx, res_nx;
    logic         done;

    always_comb begin
        d        = q;
        load_cnt = 1'b0;
        done     = 1'b0;
        take     = (q.left < q.avail) ? q.left : q.avail;
        left_nx  = q.left - q.chunk;
        avail_nx = q.avail - q.chunk;
        res_nx   = q.to_dev ? (q.res + q.chunk) : (q.res - q.chunk);

        if (dev_offer) d.avail = dev_offer_len;
        if (cnt_wr_hit) d.tc = 1'b0;
        if (irq_ack) begin
            d.irq = 1'b0;
            d.bs  = 1'b0;
        end

        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state  = ST_ARM;
                    d.res    = res_in;
                    d.cmd    = cmd_in;
                    d.tc     = 1'b0;
                    load_cnt = 1'b1;
                end
            end
            ST_ARM: begin
                if (dma_en) begin
                    d.left   = calc_len;
                    d.to_dev = calc_to_dev;
                    if (calc_len == '0) done = 1'b1;
                    else                d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (q.cmd) begin
                    d.chunk = q.left;
                    d.state = ST_XFER;
                end else if (q.avail != '0) begin
                    d.chunk = take;
                    d.state = ST_XFER;
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    d.left = left_nx;
                    if (q.cmd) begin
                        done = 1'b1;
                    end else begin
                        d.avail = avail_nx;
                        d.res   = res_nx;
                        if (avail_nx != '0 || res_nx == '0) done = 1'b1;
                        else if (left_nx != '0)            d.state = ST_RUN;
                        else                                d.state = ST_DEFER;
                    end
                end
            end
            ST_DEFER: begin
                if (dev_offer) done = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase

        if (abort && q.state != ST_IDLE) begin
            done    = 1'b0;
            d.state = ST_IDLE;
        end
        if (done) begin
            d.state = ST_IDLE;
            d.tc    = 1'b1;
            d.bs    = 1'b1;
            d.irq   = 1'b1;
        end
        clr_cnt = done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign res_q      = q.res;
    assign cmd_q      = q.cmd;
    assign busy       = (q.state != ST_IDLE);
    assign mem_req    = (q.state == ST_XFER);
    assign mem_to_dev = q.to_dev;
    assign mem_len    = q.chunk;
    assign left_q     = q.left;
    assign stat_tc    = q.tc;
    assign intr_bs    = q.bs;
    assign irq        = q.irq;

    // R6: no memory request while enable is still low
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ARM && !dma_en) |=> !mem_req);

    // R7: chunk bounded by bytes left and device bytes, never empty
    p_chunk_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !q.cmd) |-> (mem_len != '0 && mem_len <= q.left && mem_len <= q.avail));

    // R8: bytes left drop by the acknowledged chunk
    p_left_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !abort) |=> (left_q == $past(q.left) - $past(q.chunk)));

    // R9: an interrupt rises only together with the completion flags
    p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (stat_tc && intr_bs && !busy));

    // R10: deferred state holds until the device offers data
    p_defer_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DEFER && !dev_offer && !abort) |=> (q.state == ST_DEFER));

    // R11: a start clears terminal count
    p_start_tc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start && !abort) |=> !stat_tc);

    // R12: abort ends the transfer on the next edge
    p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (!busy && !mem_req));

endmodule

// File: rtl/xfer_len_ctrl.sv
module xfer_len_ctrl #(
    parameter int unsigned CNT_BYTES = 3,
    parameter int unsigned CMD_BUF   = 16,
    parameter int unsigned ZERO_LEN  = 65536
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cnt_wr,
    input  logic [$clog2(CNT_BYTES)-1:0] cnt_sel,
    input  logic [7:0]                   cnt_wdata,
    input  logic                         start,
    input  logic                         cmd_mode,
    input  logic [8*CNT_BYTES:0]         residual,
    input  logic                         dma_en,
    input  logic                         abort,
    input  logic                         dev_offer,
    input  logic [8*CNT_BYTES:0]         dev_offer_len,
    input  logic                         mem_ack,
    input  logic                         irq_ack,
    output logic                         busy,
    output logic                         mem_req,
    output logic                         mem_to_dev,
    output logic [8*CNT_BYTES:0]         mem_len,
    output logic [8*CNT_BYTES:0]         left_q,
    output logic [8*CNT_BYTES:0]         residual_q,
    output logic [8*CNT_BYTES-1:0]       count_q,
    output logic                         stat_tc,
    output logic                         intr_bs,
    output logic                         irq
);
    localparam int unsigned CNT_W = 8 * CNT_BYTES;
    localparam int unsigned W     = CNT_W + 1;
    localparam int unsigned SEL_W = $clog2(CNT_BYTES);

    logic         load_cnt, clr_cnt, wr_hit, cmd_q, calc_to_dev;
    logic [W-1:0] calc_len, res_q;

    xfer_count_regs #(.CNT_BYTES(CNT_BYTES), .SEL_W(SEL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_wr),
        .wr_sel  (cnt_sel),
        .wr_data (cnt_wdata),
        .load    (load_cnt),
        .clear   (clr_cnt),
        .count_q (count_q),
        .wr_hit  (wr_hit)
    );

    xfer_len_clamp #(.CNT_W(CNT_W), .W(W), .CMD_BUF(CMD_BUF), .ZERO_LEN(ZERO_LEN)) u_clamp (
        .count    (count_q),
        .residual (res_q),
        .cmd_mode (cmd_q),
        .len      (calc_len),
        .to_dev   (calc_to_dev)
    );

    xfer_seq #(.W(W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cmd_in        (cmd_mode),
        .res_in        (residual),
        .dma_en        (dma_en),
        .abort         (abort),
        .dev_offer     (dev_offer),
        .dev_offer_len (dev_offer_len),
        .mem_ack       (mem_ack),
        .irq_ack       (irq_ack),
        .cnt_wr_hit    (wr_hit),
        .calc_len      (calc_len),
        .calc_to_dev   (calc_to_dev),
        .load_cnt      (load_cnt),
        .clr_cnt       (clr_cnt),
        .res_q         (res_q),
        .cmd_q         (cmd_q),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_to_dev    (mem_to_dev),
        .mem_len       (mem_len),
        .left_q        (left_q),
        .stat_tc       (stat_tc),
        .intr_bs       (intr_bs),
        .irq           (irq)
    );

    assign residual_q = res_q;

    // R9: completion leaves the working count cleared
    p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (count_q == '0));

endmodule

// File: tb/sim_xfer_len_ctrl.sv
`timescale 1ns/1ps
module sim_xfer_len_ctrl;
    localparam int W = 25;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cnt_wr = 1'b0;
    logic [1:0] cnt_sel = '0;
    logic [7:0] cnt_wdata = '0;
    logic start = 1'b0, cmd_mode = 1'b0, dma_en = 1'b0, abort = 1'b0;
    logic [W-1:0] residual = '0, dev_offer_len = '0;
    logic dev_offer = 1'b0, mem_ack = 1'b0, irq_ack = 1'b0;
    logic busy, mem_req, mem_to_dev, stat_tc, intr_bs, irq;
    logic [W-1:0] mem_len, left_q, residual_q;
    logic [23:0] count_q;

    int checks = 0, fails = 0;
    longint cyc = 0;
    longint exp_avail = 0;

    always #4 clk = ~clk;

    xfer_len_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata),
        .start(start), .cmd_mode(cmd_mode), .residual(residual), .dma_en(dma_en), .abort(abort),
        .dev_offer(dev_offer), .dev_offer_len(dev_offer_len), .mem_ack(mem_ack), .irq_ack(irq_ack),
        .busy(busy), .mem_req(mem_req), .mem_to_dev(mem_to_dev), .mem_len(mem_len),
        .left_q(left_q), .residual_q(residual_q), .count_q(count_q),
        .stat_tc(stat_tc), .intr_bs(intr_bs), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog R7: actual %0d cycles expected below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint lmin(input longint a, input longint b);
        return (a < b) ? a : b;
    endfunction

    function automatic longint labs(input longint a);
        return (a < 0) ? -a : a;
    endfunction

    function automatic longint eff_of(input longint c);
        return (c == 0) ? 65536 : c;
    endfunction

    // bytes written high, low, middle: order must not matter (R1)
    task automatic write_count(input longint v);
        @(negedge clk); cnt_wr = 1'b1; cnt_sel = 2'd2; cnt_wdata = v[23:16];
        @(negedge clk); cnt_sel = 2'd0; cnt_wdata = v[7:0];
        @(negedge clk); cnt_sel = 2'd1; cnt_wdata = v[15:8];
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic offer(input longint n);
        dev_offer = 1'b1;
        dev_offer_len = W'(n);
        @(negedge clk);
        dev_offer = 1'b0;
        exp_avail = n;
    endtask

    task automatic expect_done(input string tag);
        chk(!busy && irq && stat_tc && intr_bs, tag, {busy, irq, stat_tc, intr_bs}, 4'b0111);
        chk(count_q == 0, "R9 count cleared at completion", count_q, 0);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(!irq && !intr_bs && stat_tc, "R11 ack clears irq and keeps tc",
            {irq, intr_bs, stat_tc}, 3'b001);
    endtask

    task automatic do_xfer(input longint cnt, input bit cmd, input longint res,
                           input int en_delay, input longint fixed_offer);
        longint len, left, res_m, c;
        bit dir;
        write_count(cnt);
        dma_en = (en_delay == 0);
        start = 1'b1; cmd_mode = cmd; residual = W'(res);
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R6 busy after start", busy, 1);
        chk(count_q == cnt, "R1 count reloaded", count_q, cnt);
        chk(!stat_tc, "R11 start clears tc", stat_tc, 0);
        for (int i = 0; i < en_delay; i++) begin
            @(negedge clk);
            chk(!mem_req && busy, "R6 held while enable low", {busy, mem_req}, 2'b10);
        end
        dma_en = 1'b1;
        @(negedge clk);
        len = lmin(eff_of(cnt), cmd ? 16 : labs(res));
        dir = cmd || (res < 0);
        chk(left_q == len, cmd ? "R3 command length" : (cnt == 0 ? "R2 zero count length" : "R4 data length"),
            left_q, len);
        chk(mem_to_dev == dir, "R5 direction", mem_to_dev, dir);
        if (len == 0) begin
            expect_done("R9 empty residual completes at once");
            return;
        end
        left = len;
        res_m = res;
        for (int it = 0; it < 5000; it++) begin
            if (mem_req) begin
                c = cmd ? left : lmin(left, exp_avail);
                chk(mem_len == c, "R7 chunk length", mem_len, c);
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                if (cmd) begin
                    expect_done("R3 command transfer completes");
                    return;
                end
                left -= c;
                exp_avail -= c;
                res_m = (res_m < 0) ? res_m + c : res_m - c;
                chk(left_q == left, "R8 bytes left", left_q, left);
                chk($signed(residual_q) == res_m, "R8 residual", $signed(residual_q), res_m);
                if (exp_avail != 0 || res_m == 0) begin
                    expect_done("R9 completion after chunk");
                    return;
                end
                if (left == 0) begin
                    for (int k = 0; k < 3; k++) begin
                        @(negedge clk);
                        chk(busy && !irq, "R10 completion deferred", {busy, irq}, 2'b10);
                    end
                    offer((fixed_offer != 0) ? fixed_offer : 1 + longint'($urandom % 40));
                    expect_done("R10 deferred completion on new data");
                    return;
                end
            end else if (!cmd && exp_avail == 0) begin
                chk(!mem_req, "R7 no request without device data", mem_req, 0);
                offer((fixed_offer != 0) ? fixed_offer : 1 + longint'($urandom % 40));
            end else begin
                @(negedge clk);
            end
        end
        chk(0, "R7 transfer stalled", 0, 1);
    endtask

    initial begin
        longint rc, rr;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !irq && !stat_tc && !mem_req && count_q == 0, "R9 idle after reset",
            {busy, irq, stat_tc, mem_req}, 0);

        do_xfer(10, 0, 30, 0, 10);       // R10: count and buffer run dry together
        do_xfer(8, 0, -50, 2, 0);        // R6 delay, R9 leftover device bytes
        do_xfer(40, 1, 0, 0, 0);         // R3 capped at 16
        do_xfer(5, 1, -7, 1, 0);         // R3 below the cap
        do_xfer(77, 0, 0, 0, 0);         // R9 residual zero

        write_count(24'h000123);
        chk(!stat_tc, "R11 count write clears tc", stat_tc, 0);

        // R2 and R12: zero count taken as 65536, then abandoned
        write_count(0);
        dma_en = 1'b1;
        start = 1'b1; cmd_mode = 1'b0; residual = W'(-100000);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(left_q == 65536, "R2 zero count means 65536", left_q, 65536);
        chk(mem_to_dev, "R5 negative residual reads memory", mem_to_dev, 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!busy && !mem_req && !irq, "R12 abort returns to idle", {busy, mem_req, irq}, 0);
        repeat (2) @(negedge clk);
        chk(!irq && !busy, "R12 no interrupt after abort", {busy, irq}, 0);

        for (int n = 0; n < 30; n++) begin
            case ($urandom % 4)
                0: rc = 0;
                1: rc = 1 + longint'($urandom % 60);
                2: rc = 61 + longint'($urandom % 400);
                default: rc = 24'h10000 + longint'($urandom % 24'hFFFF);
            endcase
            rr = longint'($urandom % 160);
            if ($urandom % 2) rr = -rr;
            do_xfer(rc, ($urandom % 5) == 0, rr, int'($urandom % 3), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule